// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Binary Counter

This block is a presettable binary counter, four bits wide by default. It can count in either direction. Every bit of the count register changes on the same rising clock edge. No bit clocks another bit. The counter has these controls:

- an active-low synchronous parallel load;
- two active-low count enables, a local enable and a chain enable;
- a direction select.

An active-low carry output marks the terminal count. Only the chain enable gates this carry. The carry can therefore drive the chain enable of the next stage directly. Several stages chained this way, with a shared clock and shared local enable, form one wider synchronous counter with no glue logic.

A parameter selects the increment/decrement datapath. One variant is a per-bit look-ahead toggle network. The other is a plain adder. A second parameter sets the width.

Top module: `sync_updown_counter`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high at a rising edge, the count becomes 0.
- R2: When `load_n` is sampled low at a rising edge, the count takes `din` on that edge. This holds whatever the values of the enables and the direction.
- R3: When `load_n` is high and either `local_en_n` or `chain_en_n` is high at an edge, the count holds its value.
- R4: When `load_n` is high, both enables are low and `count_up` is 1, the count increments by one on the edge. It wraps from all ones (15) to 0.
- R5: When `load_n` is high, both enables are low and `count_up` is 0, the count decrements by one on the edge. It wraps from 0 to all ones (15).
- R6: `carry_n` is combinational. It is 0 exactly when `chain_en_n` is 0 and the count is at its terminal value. The terminal value is all ones when `count_up` is 1 and 0 when `count_up` is 0.
- R7: `local_en_n` has no influence on `carry_n`.
- R8: Three stages can be chained. Each stage's `carry_n` feeds the next stage's `chain_en_n`, and the stages share the clock, `load_n`, `local_en_n` and `count_up`. The chain then behaves as a single 12-bit counter in both directions, including wrap and a load in mid-count. The carry of the last stage marks the 12-bit terminal value.
- R9: Changes on `load_n`, the enables, `count_up` or `din` between clock edges leave the count unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| local_en_n | input | 1 | Active-low count enable that does not gate the carry |
| chain_en_n | input | 1 | Active-low count enable that also gates the carry |
| count_up | input | 1 | Direction: 1 counts up, 0 counts down |
| din | input | WIDTH | Parallel load value |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low terminal-count carry |

## Verification
The bench sweeps every start value against every combination of the four control inputs. This exposes several kinds of error:

- A design that let counting override load would miss the loaded value.
- A design that gated the carry with the local enable would raise the carry while that enable is high.
- A design that decoded a fixed terminal value would give a wrong carry at 0 when counting down.

Wrap at both ends catches arithmetic that saturates instead of rolling over. Sampling the count just after mid-cycle input changes catches any path from the controls to the register that bypasses the clock edge.

A three-stage chain is then compared with a 12-bit arithmetic model through both wrap points and a mid-count load. This catches carry decode that does not follow direction, because the upper stages would step at the wrong time.

// File: rtl/sudc_pkg.sv
package sudc_pkg;
   typedef enum logic [1:0] {
      OP_HOLD = 2'd0,
      OP_LOAD = 2'd1,
      OP_INC  = 2'd2,
      OP_DEC  = 2'd3
   } sudc_op_e;
endpackage

// File: rtl/sudc_op_decode.sv
module sudc_op_decode
   import sudc_pkg::*;
(
   input  logic     load_n,
   input  logic     local_en_n,
   input  logic     chain_en_n,
   input  logic     count_up,
   output sudc_op_e op
);
   always_comb begin
      if (!load_n)
         op = OP_LOAD;
      else if (!local_en_n && !chain_en_n)
         op = count_up ? OP_INC : OP_DEC;
      else
         op = OP_HOLD;
   end
endmodule

// File: rtl/sudc_step.sv
module sudc_step #(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             count_up,
   output logic [WIDTH-1:0] nxt
);
   generate
      if (LOOKAHEAD) begin : g_toggle
         logic [WIDTH-1:0] ones_below;
         logic [WIDTH-1:0] zeros_below;
         logic [WIDTH-1:0] flip;
         assign ones_below[0]  = 1'b1;
         assign zeros_below[0] = 1'b1;
         for (genvar i = 1; i < WIDTH; i++) begin : g_chain
            assign ones_below[i]  = ones_below[i-1] & cur[i-1];
            assign zeros_below[i] = zeros_below[i-1] & ~cur[i-1];
         end
         assign flip = count_up ? ones_below : zeros_below;
         assign nxt  = cur ^ flip;
      end else begin : g_adder
         assign nxt = count_up ? cur + WIDTH'(1) : cur - WIDTH'(1);
      end
   endgenerate
endmodule

// File: rtl/sudc_terminal.sv
module sudc_terminal #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             count_up,
   input  logic             chain_en_n,
   output logic             carry_n
);
   logic at_top;
   logic at_bottom;
   logic at_end;
   assign at_top    = &cur;
   assign at_bottom = ~|cur;
   assign at_end    = count_up ? at_top : at_bottom;
   assign carry_n   = ~(at_end & ~chain_en_n);
endmodule

// File: rtl/sync_updown_counter.sv
module sync_updown_counter
   import sudc_pkg::*;
#(
   parameter int WIDTH     = 4,
   parameter bit LOOKAHEAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_n,
   input  logic             local_en_n,
   input  logic             chain_en_n,
   input  logic             count_up,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] count,
   output logic             carry_n
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("sync_updown_counter: WIDTH must be at least 2");
      end
   endgenerate

   sudc_op_e         op;
   logic [WIDTH-1:0] stepped;
   logic [WIDTH-1:0] count_q;

   sudc_op_decode u_decode (
      .load_n     (load_n),
      .local_en_n (local_en_n),
      .chain_en_n (chain_en_n),
      .count_up   (count_up),
      .op         (op)
   );

   sudc_step #(.WIDTH(WIDTH), .LOOKAHEAD(LOOKAHEAD)) u_step (
      .cur      (count_q),
      .count_up (count_up),
      .nxt      (stepped)
   );

   sudc_terminal #(.WIDTH(WIDTH)) u_term (
      .cur        (count_q),
      .count_up   (count_up),
      .chain_en_n (chain_en_n),
      .carry_n    (carry_n)
   );

   always_ff @(posedge clk) begin
      if (rst)
         count_q <= '0;
      else begin
         unique case (op)
            OP_LOAD: count_q <= din;
            OP_INC,
            OP_DEC:  count_q <= stepped;
            default: count_q <= count_q;
         endcase
      end
   end

   assign count = count_q;

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> count == '0);

   assert_load_wins_R2: assert property (@(posedge clk) disable iff (rst)
      !load_n |=> count == $past(din));

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      (load_n && (local_en_n || chain_en_n)) |=> $stable(count));

   assert_inc_R4: assert property (@(posedge clk) disable iff (rst)
      (load_n && !local_en_n && !chain_en_n && count_up)
         |=> count == $past(count) + WIDTH'(1));

   assert_dec_R5: assert property (@(posedge clk) disable iff (rst)
      (load_n && !local_en_n && !chain_en_n && !count_up)
         |=> count == $past(count) - WIDTH'(1));

   assert_carry_gated_R6: assert property (@(posedge clk) disable iff (rst)
      !carry_n |-> (!chain_en_n && (count == (count_up ? ALL_ONES : '0))));

   assert_top_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (!carry_n && count_up && !local_en_n && load_n) |=> count == '0);
endmodule

// File: tb/sync_updown_counter_bench.sv
module sync_updown_counter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 4;
   localparam int MAX_CYCLES = 200000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;

   // single stage under exhaustive sweep
   logic         rst = 1'b1;
   logic         load_n = 1'b1, local_en_n = 1'b1, chain_en_n = 1'b1, count_up = 1'b1;
   logic [W-1:0] din = '0;
   logic [W-1:0] count;
   logic         carry_n;

   sync_updown_counter #(.WIDTH(W)) u_sync_updown_counter (
      .clk(clk), .rst(rst), .load_n(load_n), .local_en_n(local_en_n),
      .chain_en_n(chain_en_n), .count_up(count_up), .din(din),
      .count(count), .carry_n(carry_n)
   );

   // three-stage chain
   logic        c_load_n = 1'b1, c_local_n = 1'b1, c_en_n = 1'b1, c_up = 1'b1;
   logic [11:0] c_din = '0;
   logic [2:0]  st_chain;
   logic [2:0]  st_carry;
   logic [3:0]  st_q [3];

   for (genvar g = 0; g < 3; g++) begin : g_stage
      if (g == 0) begin : g_first
         assign st_chain[g] = c_en_n;
      end else begin : g_next
         assign st_chain[g] = st_carry[g-1];
      end
      sync_updown_counter #(.WIDTH(4), .LOOKAHEAD(g != 1)) u_stage (
         .clk(clk), .rst(rst), .load_n(c_load_n), .local_en_n(c_local_n),
         .chain_en_n(st_chain[g]), .count_up(c_up), .din(c_din[g*4 +: 4]),
         .count(st_q[g]), .carry_n(st_carry[g])
      );
   end

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > MAX_CYCLES) begin
         n_checks = n_checks + 1;
         n_fails  = n_fails + 1;
         $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, MAX_CYCLES);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks = n_checks + 1;
      if (!ok) begin
         n_fails = n_fails + 1;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // one clock of the single stage; checks carry, mid-cycle stability, next count
   task automatic step1(input logic l, input logic p, input logic c, input logic d,
                        input logic [W-1:0] v);
      logic [W-1:0] old, exp;
      logic         exp_carry;
      string        tag;
      @(negedge clk);
      old = count;
      load_n = l; local_en_n = p; chain_en_n = c; count_up = d; din = v;
      #1;
      exp_carry = !(!c && (d ? (old == 4'hF) : (old == 4'h0)));
      check(carry_n == exp_carry, p ? "R6/R7 carry" : "R6 carry", carry_n, exp_carry);
      check(count == old, "R9 no change between edges", count, old);
      @(posedge clk);
      #2;
      if (!l) begin exp = v; tag = "R2 load"; end
      else if (!p && !c) begin
         exp = d ? old + 4'd1 : old - 4'd1;
         tag = d ? "R4 up" : "R5 down";
      end else begin exp = old; tag = "R3 hold"; end
      check(count == exp, tag, count, exp);
   endtask

   task automatic step_chain(input logic l, input logic p, input logic e, input logic d,
                             input logic [11:0] v, inout logic [11:0] model);
      logic [11:0] got;
      logic        exp_carry;
      @(negedge clk);
      c_load_n = l; c_local_n = p; c_en_n = e; c_up = d; c_din = v;
      #1;
      exp_carry = !(!e && (d ? (model == 12'hFFF) : (model == 12'h000)));
      check(st_carry[2] == exp_carry, "R8 chain carry", st_carry[2], exp_carry);
      @(posedge clk);
      #2;
      if (!l) model = v;
      else if (!p && !e) model = d ? model + 12'd1 : model - 12'd1;
      got = {st_q[2], st_q[1], st_q[0]};
      check(got == model, "R8 chain count", got, model);
   endtask

   initial begin
      logic [11:0] m;
      repeat (3) @(posedge clk);
      #2;
      check(count == 4'h0, "R1 reset", count, 0);
      check({st_q[2], st_q[1], st_q[0]} == 12'h0, "R1 chain reset",
            {st_q[2], st_q[1], st_q[0]}, 0);
      @(negedge clk);
      rst = 1'b0;

      // exhaustive sweep: every start value x every control combination
      for (int s = 0; s < 16; s++) begin
         for (int mode = 0; mode < 16; mode++) begin
            step1(1'b0, 1'b1, 1'b1, 1'b1, 4'(s));
            step1(mode[3], mode[2], mode[1], mode[0], 4'(s) ^ 4'hA);
         end
      end

      // a full lap in each direction through the wrap points
      step1(1'b0, 1'b0, 1'b0, 1'b1, 4'hE);
      for (int k = 0; k < 18; k++) step1(1'b1, 1'b0, 1'b0, 1'b1, 4'h0);
      for (int k = 0; k < 18; k++) step1(1'b1, 1'b0, 1'b0, 1'b0, 4'h0);

      // reset during counting
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #2;
      check(count == 4'h0, "R1 reset mid-run", count, 0);
      @(negedge clk);
      rst = 1'b0;

      // chained 12-bit counter
      m = 12'h000;
      step_chain(1'b0, 1'b0, 1'b0, 1'b1, 12'hFE0, m);
      for (int k = 0; k < 48; k++) step_chain(1'b1, 1'b0, 1'b0, 1'b1, 12'h0, m);
      for (int k = 0; k < 4; k++) step_chain(1'b1, 1'b1, 1'b0, 1'b1, 12'h0, m);
      for (int k = 0; k < 4; k++) step_chain(1'b1, 1'b0, 1'b1, 1'b1, 12'h0, m);
      step_chain(1'b0, 1'b0, 1'b0, 1'b0, 12'h020, m);
      for (int k = 0; k < 48; k++) step_chain(1'b1, 1'b0, 1'b0, 1'b0, 12'h0, m);
      step_chain(1'b0, 1'b0, 1'b0, 1'b1, 12'h0FD, m);
      for (int k = 0; k < 20; k++) step_chain(1'b1, 1'b0, 1'b0, 1'b1, 12'h0, m);
      step_chain(1'b0, 1'b0, 1'b0, 1'b0, 12'h301, m);
      for (int k = 0; k < 20; k++) step_chain(1'b1, 1'b0, 1'b0, 1'b0, 12'h0, m);

      finish_run();
   end
endmodule